// File: doc/BRIEF.md
# Interleaved Multiphase PWM Phase Sequencer

This block produces up to three interleaved logic-level PWM outputs for a multiphase buck regulator. It is driven by a master oscillator tick stream, which arrives as a one-cycle pulse on `tick`. It also takes one reset request per phase. Each reset request is the already-digitised result of an external ramp-versus-error comparison. On every master tick, one active phase is set, in rotation. A phase is cleared when its own reset request arrives. Because a phase may stay high for almost a whole period, several outputs can be high at once.

When `enable` rises, the block first runs a detection window lasting a fixed number of master ticks. During this window all PWM outputs stay low, and the last output is driven only weakly to a sense level. At the final tick of the window the block samples two inputs:

- a flag saying whether the last output is strapped low;
- a configuration input that forces single-phase operation.

A strapped-low last output removes that phase and runs with one fewer phase. Forced single-phase mode runs only the first phase, and sets it on every second tick. Dropping `enable` or asserting `rst` returns every output to low.

Top module: `mphase_pwm_seq`

## Requirements
- R1: While `rst` is high, or in the cycle after `enable` is sampled low, every bit of `pwm_out` is 0 and `last_sense_drive` is 0.
- R2: After `enable` is sampled high, `last_sense_drive` is 1 and `pwm_out` stays 0 until DET_TICKS master ticks have been received.
- R3: `last_strap_low` is sampled only on the final detection tick. If it is 1, the last phase (bit NUM_PH-1) never goes high in that run and the rotation covers NUM_PH-1 phases. If it is 0, all NUM_PH phases rotate.
- R4: If `force_single` is 1 on the final detection tick, only bit 0 of `pwm_out` is ever set, and it is set on every second master tick, starting with the first tick after detection.
- R5: In multiphase operation, the first tick after detection sets bit 0. Each following tick sets the next active bit in ascending order, wrapping after the last active bit. A set bit reads 1 in the cycle after its tick, and no bit rises in a cycle that did not follow a tick.
- R6: A 1 on `rst_req[i]` makes `pwm_out[i]` read 0 in the next cycle. Other bits are not affected, so several bits may be 1 at the same time.
- R7: If `rst_req[i]` is 1 in the same cycle as the tick that would set phase i, the reset wins and `pwm_out[i]` stays 0 for that period.
- R8: A phase still high when the tick just before its next set tick arrives is forced to 0 by that tick, limiting its duty.
- R9: Once detection ends, `last_sense_drive` is 0. In three-phase operation the last bit then behaves as a normal full-swing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low holds all outputs low |
| tick | input | 1 | One-cycle master oscillator tick |
| force_single | input | 1 | Forces single-phase operation when sampled at the end of detection |
| last_strap_low | input | 1 | 1 when the last PWM output is sensed as strapped to ground |
| rst_req | input | NUM_PH | Per-phase reset request from the external comparators |
| pwm_out | output | NUM_PH | Registered PWM outputs, bit 0 is the first phase |
| last_sense_drive | output | 1 | Weak sense drive on the last output during detection |

## Verification
The bench builds the block with NUM_PH = 3 and DET_TICKS = 2. This brings three-phase, two-phase and forced single-phase operation within reach of one bench. A stimulus table drives the three-phase rotation through overlapping outputs, reset requests that land on set ticks, and duty-guard releases. Directed runs then cover the other two modes and a strap flag that changes during the detection window. They also cover disabling and resetting while outputs are high.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_DET = 2'd1,
    ST_RUN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mps_seq_ctrl.sv
module mps_seq_ctrl
  import mps_pkg::*;
#(
  parameter int NUM_PH    = 3,
  parameter int DET_TICKS = 2,
  localparam int CW = $clog2(NUM_PH + 1),
  localparam int DW = $clog2(DET_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          tick,
  input  logic          force_single,
  input  logic          strap_low,
  output logic          run,
  output logic          detecting,
  output logic          single_mode,
  output logic [CW-1:0] act_cnt
);
  seq_state_e    state;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state       <= ST_OFF;
      dcnt        <= '0;
      single_mode <= 1'b0;
      act_cnt     <= CW'(NUM_PH);
    end else begin
      case (state)
        ST_OFF: begin
          state <= ST_DET;
          dcnt  <= '0;
        end
        ST_DET: begin
          if (tick) begin
            if (dcnt == DW'(DET_TICKS - 1)) begin
              state       <= ST_RUN;
              single_mode <= force_single;
              if (force_single)   act_cnt <= CW'(1);
              else if (strap_low) act_cnt <= CW'(NUM_PH - 1);
              else                act_cnt <= CW'(NUM_PH);
            end else begin
              dcnt <= dcnt + DW'(1);
            end
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign run       = (state == ST_RUN);
  assign detecting = (state == ST_DET);
endmodule

// File: rtl/mps_slot_gen.sv
module mps_slot_gen #(
  parameter int NUM_PH = 3,
  localparam int CW   = $clog2(NUM_PH + 1),
  localparam int MAXP = (NUM_PH < 2) ? 2 : NUM_PH,
  localparam int SW   = $clog2(MAXP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              single_mode,
  input  logic [CW-1:0]     act_cnt,
  output logic [NUM_PH-1:0] phase_en,
  output logic [NUM_PH-1:0] set_vec,
  output logic [NUM_PH-1:0] guard_vec
);
  logic [SW-1:0] slot;
  logic [SW-1:0] period_m1;

  always_comb begin
    if (single_mode) period_m1 = SW'(1);
    else             period_m1 = SW'(act_cnt - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot <= '0;
    end else if (tick) begin
      if (slot == period_m1) slot <= '0;
      else                   slot <= slot + SW'(1);
    end
  end

  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    logic [SW-1:0] gslot;
    if (i == 0) begin : g_first
      assign gslot       = period_m1;
      assign phase_en[i] = run;
    end else begin : g_rest
      assign gslot       = SW'(i - 1);
      assign phase_en[i] = run && !single_mode && (CW'(i) < act_cnt);
    end
    assign set_vec[i]   = phase_en[i] && tick && (slot == SW'(i));
    assign guard_vec[i] = phase_en[i] && tick && (slot == gslot);
  end
endmodule

// File: rtl/mps_phase_cell.sv
module mps_phase_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set_tick,
  input  logic guard_tick,
  input  logic clr_req,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || !en)      q <= 1'b0;
    else if (clr_req)    q <= 1'b0;
    else if (set_tick)   q <= 1'b1;
    else if (guard_tick) q <= 1'b0;
  end
endmodule

// File: rtl/mphase_pwm_seq.sv
module mphase_pwm_seq
  import mps_pkg::*;
#(
  parameter int NUM_PH    = 3,
  parameter int DET_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic              force_single,
  input  logic              last_strap_low,
  input  logic [NUM_PH-1:0] rst_req,
  output logic [NUM_PH-1:0] pwm_out,
  output logic              last_sense_drive
);
  localparam int CW = $clog2(NUM_PH + 1);

  logic          run, run_go, detecting, single_mode;
  logic [CW-1:0] act_cnt;
  logic [NUM_PH-1:0] phase_en, set_vec, guard_vec;

  mps_seq_ctrl #(.NUM_PH(NUM_PH), .DET_TICKS(DET_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .force_single(force_single), .strap_low(last_strap_low),
    .run(run), .detecting(detecting), .single_mode(single_mode),
    .act_cnt(act_cnt)
  );

  assign run_go = run && enable;

  mps_slot_gen #(.NUM_PH(NUM_PH)) u_slots (
    .clk(clk), .rst(rst), .run(run_go), .tick(tick),
    .single_mode(single_mode), .act_cnt(act_cnt),
    .phase_en(phase_en), .set_vec(set_vec), .guard_vec(guard_vec)
  );

  for (genvar i = 0; i < NUM_PH; i++) begin : g_cell
    mps_phase_cell u_cell (
      .clk(clk), .rst(rst), .en(phase_en[i]),
      .set_tick(set_vec[i]), .guard_tick(guard_vec[i]),
      .clr_req(rst_req[i]), .q(pwm_out[i])
    );
  end

  assign last_sense_drive = detecting;
endmodule

// File: rtl/mphase_pwm_seq_chk.sv
module mphase_pwm_seq_chk #(
  parameter int NUM_PH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              tick,
  input logic [NUM_PH-1:0] rst_req,
  input logic [NUM_PH-1:0] pwm_out,
  input logic              last_sense_drive
);
  assert_off_low_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pwm_out == '0));

  assert_off_nosense_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !last_sense_drive);

  assert_detect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    last_sense_drive |-> (pwm_out == '0));

  assert_req_clears_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pwm_out & $past(rst_req)) == '0));

  assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((pwm_out & ~$past(pwm_out)) == '0));

  assert_one_rise_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> $onehot0(pwm_out & ~$past(pwm_out)));
endmodule

bind mphase_pwm_seq mphase_pwm_seq_chk #(.NUM_PH(NUM_PH)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .tick(tick),
  .rst_req(rst_req), .pwm_out(pwm_out), .last_sense_drive(last_sense_drive)
);

// File: tb/mphase_pwm_seq_tb.sv
module mphase_pwm_seq_tb;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst, enable, tick, force_single, last_strap_low;
  logic [NP-1:0] rst_req;
  logic [NP-1:0] pwm_out;
  logic last_sense_drive;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mphase_pwm_seq #(.NUM_PH(NP), .DET_TICKS(2)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .force_single(force_single), .last_strap_low(last_strap_low),
    .rst_req(rst_req), .pwm_out(pwm_out), .last_sense_drive(last_sense_drive)
  );

  // {tick, rst_req[2:0], expected pwm_out[2:0]}, three-phase run
  localparam logic [6:0] VEC [12] = '{
    7'b1_000_001, 7'b0_000_001, 7'b1_000_011, 7'b0_001_010,
    7'b1_000_110, 7'b1_000_101, 7'b1_100_011, 7'b1_001_110,
    7'b1_001_100, 7'b0_100_000, 7'b1_010_000, 7'b1_000_100
  };

  function automatic string row_tag(int k);
    case (k)
      3, 9:    return "R6";
      8, 10:   return "R7";
      5, 6, 7: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic tk, logic [NP-1:0] req);
    tick = tk;
    rst_req = req;
    @(negedge clk);
    tick = 1'b0;
    rst_req = '0;
  endtask

  task automatic bring_up(logic strap_first, logic strap_last, logic single);
    enable = 1'b1;
    force_single = single;
    last_strap_low = strap_first;
    cyc(1'b0, '0);
    chk("R2 sense on", 32'(last_sense_drive), 32'd1);
    cyc(1'b1, '0);
    chk("R2 pwm low in detection", 32'(pwm_out), 32'd0);
    chk("R2 sense held", 32'(last_sense_drive), 32'd1);
    last_strap_low = strap_last;
    cyc(1'b1, '0);
    chk("R9 sense off", 32'(last_sense_drive), 32'd0);
    chk("R2 pwm low at end", 32'(pwm_out), 32'd0);
    force_single = 1'b0;
    last_strap_low = 1'b0;
    cyc(1'b0, '0);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; tick = 1'b0; force_single = 1'b0;
    last_strap_low = 1'b0; rst_req = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset pwm", 32'(pwm_out), 32'd0);
    chk("R1 reset sense", 32'(last_sense_drive), 32'd0);
    rst = 1'b0;
    cyc(1'b0, '0);
    chk("R1 disabled", 32'(pwm_out), 32'd0);

    // three-phase table
    bring_up(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      cyc(VEC[k][6], VEC[k][5:3]);
      chk(row_tag(k), 32'(pwm_out), 32'(VEC[k][2:0]));
    end
    chk("R9 last output drove high", 32'(pwm_out[2]), 32'd1);

    // disable with an output high
    enable = 1'b0;
    cyc(1'b0, '0);
    chk("R1 disable clears", 32'(pwm_out), 32'd0);
    cyc(1'b1, '0);
    chk("R1 ticks ignored while off", 32'(pwm_out), 32'd0);

    // two-phase: last output strapped low
    bring_up(1'b1, 1'b1, 1'b0);
    cyc(1'b1, '0); chk("R5 two-phase first", 32'(pwm_out), 32'b001);
    cyc(1'b1, '0); chk("R3 two-phase second", 32'(pwm_out), 32'b010);
    cyc(1'b1, '0); chk("R3 two-phase wrap", 32'(pwm_out), 32'b001);
    cyc(1'b1, '0); chk("R3 two-phase last off", 32'(pwm_out), 32'b010);
    chk("R9 sense stays off", 32'(last_sense_drive), 32'd0);

    // forced single phase
    enable = 1'b0;
    cyc(1'b0, '0);
    bring_up(1'b0, 1'b0, 1'b1);
    cyc(1'b1, '0); chk("R4 single set", 32'(pwm_out), 32'b001);
    cyc(1'b0, '0); chk("R4 single hold", 32'(pwm_out), 32'b001);
    cyc(1'b1, '0); chk("R4 single skip tick", 32'(pwm_out), 32'b000);
    cyc(1'b1, '0); chk("R4 single set again", 32'(pwm_out), 32'b001);
    cyc(1'b0, 3'b001); chk("R6 single cleared", 32'(pwm_out), 32'b000);
    cyc(1'b1, '0); chk("R4 no set on odd tick", 32'(pwm_out), 32'b000);

    // strap flag changing inside detection: only final tick counts
    enable = 1'b0;
    cyc(1'b0, '0);
    bring_up(1'b1, 1'b0, 1'b0);
    cyc(1'b1, '0); chk("R5 order first", 32'(pwm_out), 32'b001);
    cyc(1'b1, '0); chk("R5 order second", 32'(pwm_out), 32'b011);
    cyc(1'b1, '0); chk("R3 last phase kept", 32'(pwm_out), 32'b110);

    // synchronous reset while outputs high
    rst = 1'b1;
    cyc(1'b0, '0);
    chk("R1 reset mid run", 32'(pwm_out), 32'd0);
    rst = 1'b0;
    cyc(1'b1, '0);
    chk("R1 after reset", 32'(pwm_out), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule